// File: doc/BRIEF.md
# Three-Phase Sine Reference Generator

This block turns a stepped sine reference into three compare words for a three-phase PWM stage. On every update strobe, one per PWM carrier period, it moves its electrical angle on by one step. There are 200 steps per electrical cycle, so a 100 µs strobe gives a 50 Hz reference. For each phase it reads a fixed-point sine sample and scales it by the ratio of modulation amplitude to DC bus voltage. It then turns the bipolar result into a unipolar compare count for an up-down carrier.

The phase-A angle is θ. Phase B runs at θ − 120° and phase C at θ + 120°. The modulation index is m = 2·amp/vdc times the sine sample. Each compare word is period·(m+1)/2, which equals period/2 + period·(amp/vdc)·sin. The result is clamped to the range 0..period. A sequential divider computes the amp/vdc ratio in the background, so no divide sits on the strobe path. The three compare registers load together on the strobe edge, so a downstream shadow load always sees one consistent set.

Top module: `three_phase_sine_ref`

## Requirements
- R1: While reset is held, and after its release until the first strobe, all three compare outputs read 0. The step counter starts at angle zero, so the first strobe delivers step 1.
- R2: Each strobe advances the step index by one. After step 200 comes step 1, so the outputs repeat exactly every 200 strobes.
- R3: Step k uses the angle θ = 2π·k/200 for phase A (`cmp_a`), θ − 2π/3 for phase B (`cmp_b`) and θ + 2π/3 for phase C (`cmp_c`). All three phases use the same amplitude and have no offset.
- R4: When unclamped, each compare output equals period/2 + period·amp·sin(angle)/vdc to within 3 counts. This is period·(m+1)/2 with m = 2·amp·sin/vdc.
- R5: A result below 0 reads exactly 0, and a result above `pwm_period` reads exactly `pwm_period`.
- R6: Without a strobe, the compare outputs hold their values, even when `mod_amp`, `vdc_level` or `pwm_period` change.
- R7: All three outputs take their new values on the same clock edge: the first rising edge at which `upd_tick` is sampled high.
- R8: When `vdc_level` is 0 and `mod_amp` is nonzero, a phase with a positive sine reads `pwm_period` and a phase with a negative sine reads 0.
- R9: When `mod_amp` is 0 and `vdc_level` is nonzero, all three outputs read exactly floor(`pwm_period`/2).
- R10: A change of `mod_amp` or `vdc_level` is reflected by any strobe that comes 70 or more clock cycles after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_tick | input | 1 | One-cycle strobe per PWM period; advances the angle |
| pwm_period | input | 16 | Carrier period in counts; full-scale compare value |
| mod_amp | input | 16 | Peak reference amplitude, same units as vdc_level |
| vdc_level | input | 16 | DC bus voltage used for normalisation |
| cmp_a | output | 16 | Compare word for phase A |
| cmp_b | output | 16 | Compare word for phase B (−120°) |
| cmp_c | output | 16 | Compare word for phase C (+120°) |

## Verification
The properties assume that `upd_tick` and `pwm_period` carry known values on every sampled edge. They also assume that the compare range bound is judged against the period present at the strobe, not one changed afterwards. None of them depend on amp/vdc having settled. The stimulus changes amplitude, bus voltage and period only on falling edges, and it drives the strobe as a single-cycle pulse. Before any strobe whose value it checks, it waits at least 75 cycles after an amp/vdc change, so the background ratio is current.

// File: rtl/sgen_pkg.sv
package sgen_pkg;

  // sine sample format: signed, 15 fractional bits
  localparam int SIN_W    = 16;
  localparam int SIN_FRAC = 15;
  localparam int NPH      = 3;

  // angular direction of each phase relative to phase A, in thirds of a turn
  function automatic int phase_dir(input int p);
    case (p)
      1:       return -1;
      2:       return 1;
      default: return 0;
    endcase
  endfunction

  // quarter-wave sample t of q: round(32767 * sin(pi/2 * t/q)), integer Taylor series in Q30
  function automatic logic signed [SIN_W-1:0] qsin(input int t, input int q);
    longint x;
    longint x2;
    longint term;
    longint sum;
    longint r;
    x    = (64'sd1686629713 * longint'(t)) / longint'(q);
    x2   = (x * x) >>> 30;
    term = x;
    sum  = x;
    for (int n = 1; n <= 5; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    r = (sum * 64'sd32767 + (64'sd1 <<< 29)) >>> 30;
    if (r > 64'sd32767) r = 64'sd32767;
    if (r < 64'sd0)     r = 64'sd0;
    return r[SIN_W-1:0];
  endfunction

endpackage

// File: rtl/sgen_phase_seq.sv
module sgen_phase_seq #(
  parameter int STEPS = 200,
  parameter int IW    = 8,
  parameter int AW    = 10
) (
  input  logic                                clk,
  input  logic                                rst_s,
  input  logic                                tick,
  output logic [IW-1:0]                       idx_q,
  output logic [sgen_pkg::NPH-1:0][AW-1:0]    addr_nxt
);
  import sgen_pkg::*;

  localparam int ANG = 3 * STEPS;

  logic [IW-1:0] idx_nxt;
  logic [IW-1:0] idx_d;

  // step that the next strobe selects
  always_comb begin
    if (idx_q == IW'(STEPS)) idx_nxt = IW'(1);
    else                     idx_nxt = idx_q + IW'(1);
  end

  always_comb begin
    idx_d = idx_q;
    if (tick) idx_d = idx_nxt;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) idx_q <= IW'(STEPS);
    else        idx_q <= idx_d;
  end

  // angle addresses on a grid three times finer than the step, so 120 degrees is whole
  for (genvar p = 0; p < NPH; p++) begin : g_addr
    always_comb begin
      int v;
      v = 3 * int'(idx_nxt) + ANG + phase_dir(p) * STEPS;
      if (v >= ANG) v = v - ANG;
      if (v >= ANG) v = v - ANG;
      addr_nxt[p] = AW'(v);
    end
  end

endmodule

// File: rtl/sgen_sine_rom.sv
module sgen_sine_rom #(
  parameter int ANG = 600,
  parameter int AW  = 10
) (
  input  logic [AW-1:0]                      addr,
  output logic signed [sgen_pkg::SIN_W-1:0]  sample
);
  import sgen_pkg::*;

  localparam int Q  = ANG / 4;
  localparam int TW = $clog2(Q + 1);
  localparam logic [AW-1:0] Q1 = AW'(Q);
  localparam logic [AW-1:0] Q2 = AW'(2 * Q);
  localparam logic [AW-1:0] Q3 = AW'(3 * Q);
  localparam logic [AW-1:0] Q4 = AW'(4 * Q);

  logic signed [SIN_W-1:0] qtab [0:Q];
  logic [AW-1:0]           t_full;
  logic [TW-1:0]           t_idx;
  logic                    neg;
  logic signed [SIN_W-1:0] mag;

  for (genvar t = 0; t <= Q; t++) begin : g_tab
    assign qtab[t] = qsin(t, Q);
  end

  // fold the full turn onto the first quadrant
  always_comb begin
    neg = 1'b0;
    if (addr <= Q1) begin
      t_full = addr;
    end else if (addr <= Q2) begin
      t_full = Q2 - addr;
    end else if (addr <= Q3) begin
      t_full = addr - Q2;
      neg    = 1'b1;
    end else begin
      t_full = Q4 - addr;
      neg    = 1'b1;
    end
    t_idx = TW'(t_full);
  end

  assign mag    = qtab[t_idx];
  assign sample = neg ? -mag : mag;

endmodule

// File: rtl/sgen_gain_div.sv
module sgen_gain_div #(
  parameter int AMPW = 16,
  parameter int VW   = 16,
  parameter int GF   = 16,
  parameter int DW   = AMPW + GF
) (
  input  logic            clk,
  input  logic            rst_s,
  input  logic [AMPW-1:0] dividend,
  input  logic [VW-1:0]   divisor,
  output logic [DW-1:0]   gain
);
  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0] cnt_q,  cnt_d;
  logic [DW-1:0] quo_q,  quo_d;
  logic [VW-1:0] rem_q,  rem_d;
  logic [VW-1:0] dvs_q,  dvs_d;
  logic [DW-1:0] gain_q, gain_d;
  logic [VW:0]   rem_sh;
  logic [VW:0]   rem_diff;
  logic          fits;

  // restoring division of (dividend << GF) by divisor, restarted as soon as it ends
  always_comb begin
    cnt_d    = cnt_q;
    quo_d    = quo_q;
    rem_d    = rem_q;
    dvs_d    = dvs_q;
    gain_d   = gain_q;
    rem_sh   = {rem_q, quo_q[DW-1]};
    fits     = rem_sh >= {1'b0, dvs_q};
    rem_diff = rem_sh - {1'b0, dvs_q};
    if (cnt_q == '0) begin
      quo_d = {dividend, {GF{1'b0}}};
      rem_d = '0;
      dvs_d = divisor;
      cnt_d = CW'(DW);
    end else begin
      rem_d = fits ? rem_diff[VW-1:0] : rem_sh[VW-1:0];
      quo_d = {quo_q[DW-2:0], fits};
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) gain_d = {quo_q[DW-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      gain_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      gain_q <= gain_d;
    end
  end

  assign gain = gain_q;

endmodule

// File: rtl/sgen_duty.sv
module sgen_duty #(
  parameter int PW    = 16,
  parameter int GW    = 32,
  parameter int SW    = 16,
  parameter int SHIFT = 31
) (
  input  logic [PW-1:0]        period,
  input  logic [GW-1:0]        gain,
  input  logic signed [SW-1:0] sample,
  output logic [PW-1:0]        cmp
);
  localparam int PRODW = PW + GW + SW + 2;

  logic signed [PRODW-1:0] prod;
  logic signed [PRODW-1:0] term;
  logic signed [PRODW-1:0] res;

  // period/2 + period * gain * sample, then clamp to 0..period
  always_comb begin
    prod = $signed({1'b0, period}) * $signed({1'b0, gain}) * sample;
    term = prod >>> SHIFT;
    res  = $signed({1'b0, period >> 1}) + term;
    if (res < 0)                              cmp = '0;
    else if (res > $signed({1'b0, period}))   cmp = period;
    else                                      cmp = res[PW-1:0];
  end

endmodule

// File: rtl/three_phase_sine_ref.sv
module three_phase_sine_ref #(
  parameter int PW        = 16,
  parameter int AMP_W     = 16,
  parameter int VDC_W     = 16,
  parameter int STEPS     = 200,
  parameter int GAIN_FRAC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_tick,
  input  logic [PW-1:0]    pwm_period,
  input  logic [AMP_W-1:0] mod_amp,
  input  logic [VDC_W-1:0] vdc_level,
  output logic [PW-1:0]    cmp_a,
  output logic [PW-1:0]    cmp_b,
  output logic [PW-1:0]    cmp_c
);
  import sgen_pkg::*;

  localparam int ANG = 3 * STEPS;
  localparam int AW  = $clog2(ANG);
  localparam int IW  = $clog2(STEPS + 1);
  localparam int GW  = AMP_W + GAIN_FRAC;

  logic rst_meta;
  logic rst_s;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [IW-1:0]            idx_q;
  logic [NPH-1:0][AW-1:0]   addr_nxt;
  logic [GW-1:0]            gain;
  logic [NPH-1:0][PW-1:0]   duty_cmp;
  logic [NPH-1:0][PW-1:0]   cmp_q;
  logic [NPH-1:0][PW-1:0]   cmp_d;

  sgen_phase_seq #(.STEPS(STEPS), .IW(IW), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_s    (rst_s),
    .tick     (upd_tick),
    .idx_q    (idx_q),
    .addr_nxt (addr_nxt)
  );

  sgen_gain_div #(.AMPW(AMP_W), .VW(VDC_W), .GF(GAIN_FRAC), .DW(GW)) u_div (
    .clk      (clk),
    .rst_s    (rst_s),
    .dividend (mod_amp),
    .divisor  (vdc_level),
    .gain     (gain)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic signed [SIN_W-1:0] sample;

    sgen_sine_rom #(.ANG(ANG), .AW(AW)) u_rom (
      .addr   (addr_nxt[p]),
      .sample (sample)
    );

    sgen_duty #(.PW(PW), .GW(GW), .SW(SIN_W), .SHIFT(GAIN_FRAC + SIN_FRAC)) u_duty (
      .period (pwm_period),
      .gain   (gain),
      .sample (sample),
      .cmp    (duty_cmp[p])
    );
  end

  // all phases load on one enable so the set stays consistent
  always_comb begin
    cmp_d = cmp_q;
    if (upd_tick) cmp_d = duty_cmp;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end

  assign cmp_a = cmp_q[0];
  assign cmp_b = cmp_q[1];
  assign cmp_c = cmp_q[2];

endmodule

// File: rtl/sgen_checker.sv
module sgen_checker #(
  parameter int PW    = 16,
  parameter int STEPS = 200,
  parameter int IW    = 8
) (
  input logic          clk,
  input logic          rst_s,
  input logic          tick,
  input logic [PW-1:0] period,
  input logic [PW-1:0] ca,
  input logic [PW-1:0] cb,
  input logic [PW-1:0] cc,
  input logic [IW-1:0] idx
);

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_s |=> (ca == '0 && cb == '0 && cc == '0))
    else $error("reset left a compare output nonzero");

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_s)
    tick |=> (idx == (($past(idx) == IW'(STEPS)) ? IW'(1) : $past(idx) + IW'(1))))
    else $error("step index did not advance or wrap");

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (idx >= IW'(1) && idx <= IW'(STEPS)))
    else $error("step index out of range");

  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_s)
    !tick |=> $stable(idx))
    else $error("step index moved without strobe");

  p_cmp_hold_r6: assert property (@(posedge clk) disable iff (!rst_s)
    !tick |=> ($stable(ca) && $stable(cb) && $stable(cc)))
    else $error("compare output moved without strobe");

  p_cmp_range_r5: assert property (@(posedge clk) disable iff (!rst_s)
    tick |=> (ca <= $past(period) && cb <= $past(period) && cc <= $past(period)))
    else $error("compare output above period");

endmodule

bind three_phase_sine_ref sgen_checker #(.PW(PW), .STEPS(STEPS), .IW(IW)) u_chk (
  .clk    (clk),
  .rst_s  (rst_s),
  .tick   (upd_tick),
  .period (pwm_period),
  .ca     (cmp_a),
  .cb     (cmp_b),
  .cc     (cmp_c),
  .idx    (idx_q)
);

// File: tb/tb_three_phase_sine_ref.sv
module tb_three_phase_sine_ref;

  localparam int  CLK_PERIOD = 10;
  localparam int  STEPS      = 200;
  localparam int  TOL        = 3;
  localparam real PI         = 3.14159265358979;
  // walk table: period, amplitude, bus voltage, strobes
  localparam int  NVEC = 4;
  localparam int  VEC [NVEC][4] = '{
    '{4000,  60, 200, 30},
    '{5000, 150, 300, 30},
    '{2000,  50, 400, 30},
    '{3000, 120, 240, 30}
  };

  logic        clk;
  logic        rst_n;
  logic        upd_tick;
  logic [15:0] pwm_period;
  logic [15:0] mod_amp;
  logic [15:0] vdc_level;
  logic [15:0] cmp_a;
  logic [15:0] cmp_b;
  logic [15:0] cmp_c;

  int n_chk;
  int n_bad;
  int k;
  bit done;

  three_phase_sine_ref dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_tick   (upd_tick),
    .pwm_period (pwm_period),
    .mod_amp    (mod_amp),
    .vdc_level  (vdc_level),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .cmp_c      (cmp_c)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int exp_cmp(input int p, input int a, input int v, input int step, input int ph);
    real ang;
    real s;
    real val;
    ang = 2.0 * PI * step / STEPS + ph * 2.0 * PI / 3.0;
    s   = $sin(ang);
    if (v == 0) begin
      if (s > 1.0e-9)  return p;
      if (s < -1.0e-9) return 0;
      return p / 2;
    end
    val = p / 2.0 + p * a * s / v;
    if (val < 0.0)     return 0;
    if (val > p * 1.0) return p;
    return $rtoi(val + 0.5);
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int exp, input int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d > tol || d < -tol) begin
      n_bad++;
      $display("FAIL %s %s step=%0d actual=%0d expected=%0d", req, what, k, act, exp);
    end
  endtask

  task automatic check_phases(input string req, input int p, input int a, input int v, input int tol);
    check_int(req, "cmp_a", int'(cmp_a), exp_cmp(p, a, v, k, 0), tol);
    check_int(req, "cmp_b", int'(cmp_b), exp_cmp(p, a, v, k, -1), tol);
    check_int(req, "cmp_c", int'(cmp_c), exp_cmp(p, a, v, k, 1), tol);
  endtask

  task automatic do_tick();
    @(negedge clk) upd_tick = 1'b1;
    @(negedge clk) upd_tick = 1'b0;
    k = (k == STEPS) ? 1 : k + 1;
  endtask

  task automatic set_cfg(input int p, input int a, input int v, input int settle);
    @(negedge clk);
    pwm_period = 16'(p);
    mod_amp    = 16'(a);
    vdc_level  = 16'(v);
    repeat (settle) @(negedge clk);
  endtask

  task automatic tick_to(input int target);
    while (k != target) do_tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog step=%0d actual=hung expected=finished", k);
      summary();
      $finish;
    end
  end

  initial begin
    int a1;
    int b1;
    int c1;
    n_chk      = 0;
    n_bad      = 0;
    done       = 1'b0;
    k          = 0;
    rst_n      = 1'b0;
    upd_tick   = 1'b0;
    pwm_period = 16'd4000;
    mod_amp    = 16'd60;
    vdc_level  = 16'd200;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);

    // R1: zero outputs before any strobe
    check_int("R1", "cmp_a", int'(cmp_a), 0, 0);
    check_int("R1", "cmp_b", int'(cmp_b), 0, 0);
    check_int("R1", "cmp_c", int'(cmp_c), 0, 0);

    // R3 / R4: table walk over several period / ratio settings
    for (int i = 0; i < NVEC; i++) begin
      set_cfg(VEC[i][0], VEC[i][1], VEC[i][2], 100);
      for (int n = 0; n < VEC[i][3]; n++) begin
        do_tick();
        check_phases("R4", VEC[i][0], VEC[i][1], VEC[i][2], TOL);
      end
    end

    // R2: wrap from step 200 to step 1, and exact repeat after 200 strobes
    set_cfg(4000, 60, 200, 100);
    tick_to(STEPS);
    check_phases("R2", 4000, 60, 200, TOL);
    do_tick();
    check_int("R2", "step", k, 1, 0);
    check_phases("R3", 4000, 60, 200, TOL);
    a1 = int'(cmp_a);
    b1 = int'(cmp_b);
    c1 = int'(cmp_c);
    for (int n = 0; n < STEPS; n++) do_tick();
    check_int("R2", "cmp_a repeat", int'(cmp_a), a1, 0);
    check_int("R2", "cmp_b repeat", int'(cmp_b), b1, 0);
    check_int("R2", "cmp_c repeat", int'(cmp_c), c1, 0);

    // R6: inputs change with no strobe, outputs hold
    a1 = int'(cmp_a);
    b1 = int'(cmp_b);
    c1 = int'(cmp_c);
    set_cfg(3000, 90, 150, 100);
    check_int("R6", "cmp_a hold", int'(cmp_a), a1, 0);
    check_int("R6", "cmp_b hold", int'(cmp_b), b1, 0);
    check_int("R6", "cmp_c hold", int'(cmp_c), c1, 0);

    // R7: one strobe, all three phases carry the new step together
    do_tick();
    check_phases("R7", 3000, 90, 150, TOL);

    // R10: ratio change picked up by a strobe 75 cycles later
    set_cfg(3000, 40, 150, 75);
    do_tick();
    check_phases("R10", 3000, 40, 150, TOL);

    // R5: overdriven reference clamps exactly to the rails
    set_cfg(1000, 400, 200, 100);
    tick_to(50);
    check_int("R5", "cmp_a top", int'(cmp_a), 1000, 0);
    check_int("R5", "cmp_b bottom", int'(cmp_b), 0, 0);
    check_int("R5", "cmp_c bottom", int'(cmp_c), 0, 0);
    tick_to(150);
    check_int("R5", "cmp_a bottom", int'(cmp_a), 0, 0);
    check_int("R5", "cmp_b top", int'(cmp_b), 1000, 0);

    // R8: zero bus voltage saturates by sign
    set_cfg(2000, 100, 0, 100);
    tick_to(25);
    check_int("R8", "cmp_a", int'(cmp_a), 2000, 0);
    check_int("R8", "cmp_b", int'(cmp_b), 0, 0);
    check_int("R8", "cmp_c", int'(cmp_c), 2000, 0);

    // R9: zero amplitude gives half period on every phase, odd period
    set_cfg(1001, 0, 300, 100);
    for (int n = 0; n < 2; n++) begin
      do_tick();
      check_int("R9", "cmp_a", int'(cmp_a), 500, 0);
      check_int("R9", "cmp_b", int'(cmp_b), 500, 0);
      check_int("R9", "cmp_c", int'(cmp_c), 500, 0);
    end

    // R1: reset in mid-run clears outputs and restarts at step 1
    @(negedge clk) rst_n = 1'b0;
    pwm_period = 16'd4000;
    mod_amp    = 16'd60;
    vdc_level  = 16'd200;
    repeat (2) @(negedge clk);
    check_int("R1", "cmp_a in reset", int'(cmp_a), 0, 0);
    check_int("R1", "cmp_b in reset", int'(cmp_b), 0, 0);
    check_int("R1", "cmp_c in reset", int'(cmp_c), 0, 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    k = 0;
    do_tick();
    check_phases("R1", 4000, 60, 200, TOL);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule